// File: doc/BRIEF.md
# Serial Register Write Slave with Ready Handshake

This block is an SPI slave (mode 0) that accepts register write commands from a host and turns them into writes on a simple parallel register port. The host lowers chip select and sends an 8-bit write opcode, then an 8-bit register address, and then one or more 16-bit data words. All fields are sent most-significant bit first. Every complete word is written to the same address. The host can end a frame after a single word, or it can keep clocking so that several words stream into one register.

The serial clock, chip select and serial input are brought into the system clock domain through two-flop synchronizers. Each committed word drives a one-cycle write strobe together with its address and data. At the same moment the ready output drops low for an execution window whose length depends on the address. A word that completes while a window is still open waits in a one-deep holding register. A further word that arrives while that holding register is full raises an overrun flag and is discarded. The serial output is held at zero, because the block only accepts writes.

Top module: `spi_reg_writer`

## Requirements
- R1: A frame begins when `csN` falls. Bits are sampled on rising `sckIn` edges. The first 8 bits are the opcode, and the write opcode is 8'h02. The next ADDR_W bits are the register address. Both fields are sent MSB first.
- R2: Each 16-bit data word is received MSB first. It is presented as a single-cycle `regWrEn` pulse, with `regAddr` and `regData` valid in that cycle. Both values stay stable until the next pulse.
- R3: While `csN` stays low, further 16-bit words follow directly after one another. Each word produces its own write to the same frame address, in the order the words were sent.
- R4: Each write opens an execution window in which `ready` is low for exactly EXEC_BASE + EXEC_STEP * addr[EXEC_SEL_W-1:0] cycles. The `regWrEn` pulse falls in the first cycle of that window.
- R5: A frame whose opcode is not 8'h02 is ignored until `csN` rises. It causes no writes, and `ready` stays high.
- R6: If `csN` rises in the middle of any field, the frame is aborted. A partially received word is not written. The next frame is decoded from its first bit.
- R7: A word that completes while `ready` is low is held. It is written, with its own execution window, after `ready` has been high for one cycle.
- R8: A word that completes while the holding register is already full is discarded and sets `overrun`. `overrun` stays set until `csN` next falls.
- R9: `miso` is 0 at all times.
- R10: After reset, `ready` is 1, and `regWrEn` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the host (mode 0) |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, held at 0 |
| ready | output | 1 | High when the block can take a new word |
| regWrEn | output | 1 | One-cycle register write strobe |
| regAddr | output | ADDR_W | Register address of the current write |
| regData | output | DATA_W | Data of the current write |
| overrun | output | 1 | A word was dropped because the holding register was full |

## Verification
The bench builds the block with EXEC_BASE=6, EXEC_STEP=200 and EXEC_SEL_W=2. Addresses whose low bits are 0 therefore get a 6-cycle window, while addresses with low bits 1, 2 or 3 get windows of 206, 406 and 606 cycles. With a 128-cycle word time, the longer windows let a second word wait in the holding register, and a 3-word burst to an address with low bits 3 forces an overrun. These settings reach both the queued-write case and the dropped-word case with ordinary frames.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  localparam int OPC_W = 8;
  localparam logic [OPC_W-1:0] WR_OPCODE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } frameState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic latchAddr;
    logic loadHold;
    logic commit;
    logic flagOverrun;
    logic clrOverrun;
  } dpCtrl_t;

endpackage

// File: rtl/spiw_datapath.sv
module spiw_datapath
  import spiw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csIn,
  input  logic              mosiIn,
  input  dpCtrl_t           ctl,
  output logic              sampleEn,
  output logic              csHigh,
  output logic              csFall,
  output logic [OPC_W-1:0]  opcNext,
  output logic [ADDR_W-1:0] holdAddr,
  output logic              holdValid,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regData,
  output logic              overrun
);

  // bit order {mosi, cs, sck}; chip select idles high
  localparam logic [2:0] SYNC_RST = 3'b010;

  logic [2:0] rawIn, stg1, stg2;
  logic       sckPrev, csPrev;
  logic       sckS, csS, mosiS;

  logic [DATA_W-1:0] shiftQ, shiftNext, holdQ;
  logic [ADDR_W-1:0] curAddrQ, holdAddrQ, wrAddrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic              holdValidQ, wrEnQ, overrunQ;

  assign rawIn = {mosiIn, csIn, sckIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg1    <= SYNC_RST;
      stg2    <= SYNC_RST;
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      stg1    <= rawIn;
      stg2    <= stg1;
      sckPrev <= stg2[0];
      csPrev  <= stg2[1];
    end
  end

  assign sckS  = stg2[0];
  assign csS   = stg2[1];
  assign mosiS = stg2[2];

  assign sampleEn = sckS & ~sckPrev & ~csS;
  assign csHigh   = csS;
  assign csFall   = ~csS & csPrev;

  assign shiftNext = {shiftQ[DATA_W-2:0], mosiS};
  assign opcNext   = shiftNext[OPC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ     <= '0;
      curAddrQ   <= '0;
      holdQ      <= '0;
      holdAddrQ  <= '0;
      holdValidQ <= 1'b0;
      wrEnQ      <= 1'b0;
      wrAddrQ    <= '0;
      wrDataQ    <= '0;
      overrunQ   <= 1'b0;
    end else begin
      if (ctl.shiftEn)   shiftQ   <= shiftNext;
      if (ctl.latchAddr) curAddrQ <= shiftNext[ADDR_W-1:0];

      if (ctl.loadHold) begin
        holdQ      <= shiftNext;
        holdAddrQ  <= curAddrQ;
        holdValidQ <= 1'b1;
      end else if (ctl.commit) begin
        holdValidQ <= 1'b0;
      end

      wrEnQ <= ctl.commit;
      if (ctl.commit) begin
        wrAddrQ <= holdAddrQ;
        wrDataQ <= holdQ;
      end

      if (ctl.clrOverrun)       overrunQ <= 1'b0;
      else if (ctl.flagOverrun) overrunQ <= 1'b1;
    end
  end

  assign holdAddr  = holdAddrQ;
  assign holdValid = holdValidQ;
  assign regWrEn   = wrEnQ;
  assign regAddr   = wrAddrQ;
  assign regData   = wrDataQ;
  assign overrun   = overrunQ;

endmodule

// File: rtl/spiw_control.sv
module spiw_control
  import spiw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int EXEC_BASE  = 4,
  parameter int EXEC_STEP  = 2,
  parameter int EXEC_SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              csHigh,
  input  logic              csFall,
  input  logic [OPC_W-1:0]  opcNext,
  input  logic [ADDR_W-1:0] holdAddr,
  input  logic              holdValid,
  output dpCtrl_t           ctl,
  output logic              ready
);

  localparam int CNT_W   = $clog2(DATA_W);
  localparam int EXEC_MAX = EXEC_BASE + EXEC_STEP * ((1 << EXEC_SEL_W) - 1);
  localparam int TMR_W   = $clog2(EXEC_MAX + 1);
  localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(OPC_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  frameState_t      state;
  logic [CNT_W-1:0] bitCnt;
  logic             fieldLast, wordDone;
  logic             busy;
  logic [TMR_W-1:0] tmr;

  function automatic logic [TMR_W-1:0] execLen(input logic [ADDR_W-1:0] a);
    return TMR_W'(EXEC_BASE + EXEC_STEP * int'(a[EXEC_SEL_W-1:0]));
  endfunction

  always_comb begin
    unique case (state)
      ST_OPC:  fieldLast = (bitCnt == OPC_LAST);
      ST_ADDR: fieldLast = (bitCnt == ADDR_LAST);
      ST_DATA: fieldLast = (bitCnt == DATA_LAST);
      default: fieldLast = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (csHigh) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (state == ST_IDLE) begin
      state  <= ST_OPC;
      bitCnt <= '0;
    end else if (sampleEn && state != ST_SKIP) begin
      bitCnt <= fieldLast ? '0 : bitCnt + 1'b1;
      if (fieldLast) begin
        unique case (state)
          ST_OPC:  state <= (opcNext == WR_OPCODE) ? ST_ADDR : ST_SKIP;
          ST_ADDR: state <= ST_DATA;
          default: state <= state;
        endcase
      end
    end
  end

  assign wordDone = sampleEn && !csHigh && state == ST_DATA && fieldLast;

  always_comb begin
    ctl             = '0;
    ctl.shiftEn     = sampleEn && !csHigh &&
                      (state == ST_OPC || state == ST_ADDR || state == ST_DATA);
    ctl.latchAddr   = sampleEn && !csHigh && state == ST_ADDR && fieldLast;
    ctl.commit      = holdValid && !busy;
    ctl.loadHold    = wordDone && (!holdValid || ctl.commit);
    ctl.flagOverrun = wordDone && holdValid && !ctl.commit;
    ctl.clrOverrun  = csFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (ctl.commit) begin
      busy <= 1'b1;
      tmr  <= execLen(holdAddr);
    end else if (busy) begin
      if (tmr == TMR_W'(1)) busy <= 1'b0;
      tmr <= tmr - 1'b1;
    end
  end

  assign ready = ~busy;

endmodule

// File: rtl/spi_reg_writer.sv
module spi_reg_writer
  import spiw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int EXEC_BASE  = 4,
  parameter int EXEC_STEP  = 2,
  parameter int EXEC_SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic              ready,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regData,
  output logic              overrun
);

  dpCtrl_t           ctl;
  logic              sampleEn, csHigh, csFall, holdValid;
  logic [OPC_W-1:0]  opcNext;
  logic [ADDR_W-1:0] holdAddr;

  spiw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csIn(csN), .mosiIn(mosi),
    .ctl(ctl), .sampleEn(sampleEn), .csHigh(csHigh), .csFall(csFall),
    .opcNext(opcNext), .holdAddr(holdAddr), .holdValid(holdValid),
    .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData), .overrun(overrun)
  );

  spiw_control #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXEC_BASE(EXEC_BASE),
    .EXEC_STEP(EXEC_STEP), .EXEC_SEL_W(EXEC_SEL_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .csHigh(csHigh),
    .csFall(csFall), .opcNext(opcNext), .holdAddr(holdAddr),
    .holdValid(holdValid), .ctl(ctl), .ready(ready)
  );

  assign miso = 1'b0;

endmodule

// File: rtl/spi_reg_writer_chk.sv
module spi_reg_writer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regData,
  input logic              overrun
);

  AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !ready); // R4

  AST_WINDOW_OPENS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> regWrEn); // R4

  AST_SINGLE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R2

  AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !regWrEn) |-> ($stable(regAddr) && $stable(regData))); // R2

  AST_STROBE_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(ready)); // R7

  AST_OVERRUN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(!ready)); // R8

endmodule

bind spi_reg_writer spi_reg_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .ready(ready), .regWrEn(regWrEn),
  .regAddr(regAddr), .regData(regData), .overrun(overrun)
);

// File: tb/spi_reg_writer_test.sv
`timescale 1ns/1ps
module spi_reg_writer_test;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int EXEC_BASE = 6;
  localparam int EXEC_STEP = 200;
  localparam int EXEC_SEL_W = 2;
  localparam int HALF = 4;
  localparam int MAXW = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, ready, regWrEn, overrun;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] regData;

  int vectors = 0, fails = 0;
  int nGot = 0, nLow = 0, lowRun = 0, misoBad = 0;
  int nExp = 0, cursor = 0;
  logic [ADDR_W-1:0] gotAddr [MAXW];
  logic [DATA_W-1:0] gotData [MAXW];
  int lows [MAXW];
  logic [ADDR_W-1:0] expAddr [MAXW];
  logic [DATA_W-1:0] expData [MAXW];

  always #4 clk = ~clk;

  spi_reg_writer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXEC_BASE(EXEC_BASE),
    .EXEC_STEP(EXEC_STEP), .EXEC_SEL_W(EXEC_SEL_W)
  ) uut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csN(csN), .mosi(mosi),
    .miso(miso), .ready(ready), .regWrEn(regWrEn), .regAddr(regAddr),
    .regData(regData), .overrun(overrun)
  );

  function automatic int expLen(input logic [ADDR_W-1:0] a);
    return EXEC_BASE + EXEC_STEP * int'(a % (1 << EXEC_SEL_W));
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn && nGot < MAXW) begin
        gotAddr[nGot] = regAddr;
        gotData[nGot] = regData;
        nGot++;
      end
      if (!ready) lowRun++;
      else if (lowRun > 0) begin
        if (nLow < MAXW) lows[nLow] = lowRun;
        nLow++;
        lowRun = 0;
      end
      if (miso !== 1'b0) misoBad++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      waitClk(HALF);
      sckIn = 1'b1;
      waitClk(HALF);
      sckIn = 1'b0;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    waitClk(2 * HALF);
  endtask

  task automatic csHighT();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(4 * HALF);
  endtask

  task automatic expectWr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    expAddr[nExp] = a;
    expData[nExp] = d;
    nExp++;
  endtask

  // full write frame with nw words
  task automatic writeFrame(input logic [ADDR_W-1:0] a, input int nw,
                            input logic [DATA_W-1:0] d0, input logic [DATA_W-1:0] d1,
                            input logic [DATA_W-1:0] d2);
    csLow();
    sendBits(32'h02, 8);
    sendBits(32'(a), ADDR_W);
    sendBits(32'(d0), DATA_W);
    if (nw > 1) sendBits(32'(d1), DATA_W);
    if (nw > 2) sendBits(32'(d2), DATA_W);
    csHighT();
  endtask

  task automatic settle(input string req);
    waitClk(1500);
    check(nGot == nExp, req, "write count", nGot, nExp);
    check(nLow == nExp, req, "window count", nLow, nExp);
    for (int i = cursor; i < nExp && i < nGot; i++) begin
      check(gotAddr[i] == expAddr[i], req, "address", gotAddr[i], expAddr[i]);
      check(gotData[i] == expData[i], req, "data", gotData[i], expData[i]);
      if (i < nLow)
        check(lows[i] == expLen(expAddr[i]), "R4", "window length", lows[i],
              expLen(expAddr[i]));
    end
    cursor = nExp;
    nGot = nExp;
    nLow = nExp;
  endtask

  initial begin
    waitClk(190000);
    check(1'b0, "watchdog", "timeout", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R10 reset state
    check(ready == 1'b1, "R10", "ready", ready, 1);
    check(regWrEn == 1'b0, "R10", "regWrEn", regWrEn, 0);
    check(overrun == 1'b0, "R10", "overrun", overrun, 0);

    // R1 R2 single word, short window
    writeFrame(8'hA4, 1, 16'hBEEF, 16'h0, 16'h0);
    expectWr(8'hA4, 16'hBEEF);
    settle("R1");

    // R3 multi-word, short window
    writeFrame(8'h10, 3, 16'h1234, 16'h8001, 16'hFFFF);
    expectWr(8'h10, 16'h1234); expectWr(8'h10, 16'h8001); expectWr(8'h10, 16'hFFFF);
    settle("R3");

    // R7 queued word: 206-cycle window exceeds word time
    writeFrame(8'h21, 2, 16'h0F0F, 16'hA5A5, 16'h0);
    expectWr(8'h21, 16'h0F0F); expectWr(8'h21, 16'hA5A5);
    settle("R7");

    // R5 wrong opcode ignored
    csLow();
    sendBits(32'h03, 8); sendBits(32'h44, 8); sendBits(32'h5555, 16);
    csHighT();
    check(ready == 1'b1, "R5", "ready after ignored frame", ready, 1);
    settle("R5");

    // R6 abort mid-opcode, mid-word, then fresh frames
    csLow(); sendBits(32'h0, 5); csHighT();
    csLow(); sendBits(32'h02, 8); sendBits(32'h33, 8); sendBits(32'h2AB, 10); csHighT();
    writeFrame(8'h5C, 1, 16'hC3C3, 16'h0, 16'h0);
    expectWr(8'h5C, 16'hC3C3);
    csLow(); sendBits(32'h02, 8); sendBits(32'h60, 8); sendBits(32'h7777, 16);
    sendBits(32'h12, 7); csHighT();
    expectWr(8'h60, 16'h7777);
    settle("R6");

    // R8 overrun: 606-cycle window, three words
    writeFrame(8'h43, 3, 16'h1111, 16'h2222, 16'h3333);
    expectWr(8'h43, 16'h1111); expectWr(8'h43, 16'h2222);
    check(overrun == 1'b1, "R8", "overrun set", overrun, 1);
    settle("R8");
    check(overrun == 1'b1, "R8", "overrun held", overrun, 1);
    csLow();
    check(overrun == 1'b0, "R8", "overrun cleared on frame start", overrun, 0);
    sendBits(32'hFF, 8); sendBits(32'h12, 8);
    csHighT();
    settle("R5");

    // random frames, addresses with short or medium windows
    for (int f = 0; f < 20; f++) begin
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d0, d1, d2;
      int nw;
      a = ADDR_W'($urandom) & 8'hFD;
      nw = 1 + int'($urandom % 3);
      d0 = DATA_W'($urandom); d1 = DATA_W'($urandom); d2 = DATA_W'($urandom);
      writeFrame(a, nw, d0, d1, d2);
      expectWr(a, d0);
      if (nw > 1) expectWr(a, d1);
      if (nw > 2) expectWr(a, d2);
      settle("R3");
      check(overrun == 1'b0, "R8", "no overrun in random frame", overrun, 0);
    end

    check(misoBad == 0, "R9", "miso nonzero cycles", misoBad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule